// File: doc/BRIEF.md
# Channel-Selective Recursive Smoothing Filter for Conversion Results

This block sits on the stream of 12-bit conversion results leaving an analog-to-digital converter controller. Each result carries a 4-bit tag naming where it came from: bit 3 is the converter unit and bits 2:0 are the input channel. The block holds two independent smoothing units. Each unit is set through a small configuration port with a tag selector and a factor code. When an incoming result's tag equals a unit's selector, that unit runs a first-order recursive average, new = prev·(k-1)/k + sample/k, and the block outputs the smoothed value in place of the raw one.

Results whose tags match no enabled unit pass through with their data unchanged. Every result leaves the block one clock after it enters, whether or not it was filtered, so downstream logic sees the same latency for all channels. A clear input restarts both averages without touching their configuration.

Top module: `adc_smooth_filter`

## Requirements
- R1: After synchronous reset, out_valid is 0 and both units are disabled (selector 4'hF, factor code 0), so every result passes through with out_filtered = 0.
- R2: Factor codes map to k as 1→2, 2→4, 3→8, 4→16, 5→64. Codes 0, 6 and 7 disable the unit. A selector of 4'hF also disables it.
- R3: The first matching result after reset, after clr_i, or after that unit's configuration is written loads the average directly, and out_data equals that result's data.
- R4: Each later matching result updates a 18-bit average (12 integer bits, 6 fractional bits) as acc − (acc >> s) + ((data << 6) >> s) with k = 2^s. out_data is the integer part of the updated average.
- R5: A result that matches no enabled unit leaves with its data unchanged and out_filtered = 0, and it does not change the state of either unit.
- R6: clr_i restarts both averages (the next matching result loads directly, as in R3) and keeps their selectors and factor codes.
- R7: out_valid is high exactly one cycle after in_valid, with out_tag equal to the input's tag. out_valid is low in every other cycle.
- R8: The two units keep separate state. When both match the same tag, both update, and unit 0 supplies out_data.
- R9: A configuration write with cfg_we = 1 sets the selector and factor code of the unit named by cfg_unit (0 or 1) only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | 1 | Unit addressed by the write |
| cfg_tag | input | 4 | Selector value: unit in bit 3, channel in bits 2:0 |
| cfg_code | input | 3 | Factor code |
| clr_i | input | 1 | Restart both averages |
| in_valid | input | 1 | Input result valid |
| in_tag | input | 4 | Input result tag |
| in_data | input | 12 | Input result value |
| out_valid | output | 1 | Output result valid |
| out_tag | output | 4 | Output result tag |
| out_data | output | 12 | Smoothed or passed-through value |
| out_filtered | output | 1 | Output came from a smoothing unit |

## Verification
The bench goes after the first sample after reset, clear and reconfiguration. A design that averaged against a zero start would output roughly data/k there instead of the data. It runs every legal factor against full-scale steps, where an accumulator with too few bits would wrap or drift, and it uses the disabling codes 0, 6, 7 and selector 4'hF, where a loose decode would filter results it should pass. It also sends a shared tag to both units and then disables unit 0, which shows whether unit 1 kept updating behind the priority choice. It interleaves unmatched results between matched ones: a design that let them disturb a unit's state would return the wrong average on that unit's next sample.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  localparam int DW     = 12;            // result width
  localparam int TW     = 4;             // tag width
  localparam int CW     = 3;             // factor code width
  localparam int FRAC   = 6;             // fractional guard bits
  localparam int AW     = DW + FRAC;     // accumulator width
  localparam int NUNITS = 2;
  localparam int UW     = $clog2(NUNITS);
  localparam logic [TW-1:0] SEL_OFF = '1;

  // factor code -> shift amount (log2 k); 0 means unit disabled
  function automatic logic [2:0] code_shift(input logic [CW-1:0] c);
    case (c)
      3'd1: return 3'd1;
      3'd2: return 3'd2;
      3'd3: return 3'd3;
      3'd4: return 3'd4;
      3'd5: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic code_ok(input logic [CW-1:0] c);
    return code_shift(c) != 3'd0;
  endfunction

  // one recursive averaging step: acc*(k-1)/k + din/k in fixed point
  function automatic logic [AW-1:0] iir_step(input logic [AW-1:0] acc,
                                             input logic [DW-1:0] din,
                                             input logic [2:0]    sh);
    logic [AW-1:0] scaled;
    scaled = {din, {FRAC{1'b0}}};
    return acc - (acc >> sh) + (scaled >> sh);
  endfunction
endpackage

// File: rtl/adcf_unit.sv
module adcf_unit
  import adcf_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_tag,
  input  logic [CW-1:0] cfg_code,
  input  logic          in_valid,
  input  logic [TW-1:0] in_tag,
  input  logic [DW-1:0] in_data,
  output logic          hit,
  output logic [DW-1:0] filt
);
  localparam logic [AW-1:0] ACC_MAX = {{DW{1'b1}}, {FRAC{1'b0}}};

  logic [TW-1:0] sel_q;
  logic [CW-1:0] code_q;
  logic          primed_q;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_d;
  logic          enabled;
  logic          load_first;

  assign enabled    = (sel_q != SEL_OFF) && code_ok(code_q);
  assign hit        = in_valid && enabled && (in_tag == sel_q);
  assign load_first = hit && !primed_q;

  always_comb begin
    if (primed_q) acc_d = iir_step(acc_q, in_data, code_shift(code_q));
    else          acc_d = {in_data, {FRAC{1'b0}}};
  end
  assign filt = acc_d[AW-1:FRAC];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SEL_OFF;
      code_q   <= '0;
      primed_q <= 1'b0;
      acc_q    <= '0;
    end else if (cfg_we) begin
      sel_q    <= cfg_tag;
      code_q   <= cfg_code;
      primed_q <= 1'b0;
    end else if (clr) begin
      primed_q <= 1'b0;
    end else if (hit) begin
      acc_q    <= acc_d;
      primed_q <= 1'b1;
    end
  end

  // R3: first matching sample loads the average directly
  a_r3_first_load: assert property (@(posedge clk) disable iff (rst)
    load_first && !cfg_we && !clr |=> acc_q == {$past(in_data), {FRAC{1'b0}}});
  // R4: the average never exceeds full scale
  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    acc_q <= ACC_MAX);
  // R5: without a hit the average is untouched
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(acc_q));
  // R6: clear restarts the average
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !primed_q);
endmodule

// File: rtl/adcf_out.sv
module adcf_out
  import adcf_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [TW-1:0] in_tag,
  input  logic [DW-1:0] in_data,
  input  logic [NUNITS-1:0] hits,
  input  logic [DW-1:0] filts [NUNITS],
  output logic          out_valid,
  output logic [TW-1:0] out_tag,
  output logic [DW-1:0] out_data,
  output logic          out_filtered
);
  logic [DW-1:0] pick;

  // lowest-numbered matching unit wins
  always_comb begin
    pick = in_data;
    for (int u = NUNITS - 1; u >= 0; u--) begin
      if (hits[u]) pick = filts[u];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_tag      <= '0;
      out_data     <= '0;
      out_filtered <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_filtered <= |hits;
      if (in_valid) begin
        out_tag  <= in_tag;
        out_data <= pick;
      end
    end
  end
endmodule

// File: rtl/adc_smooth_filter.sv
module adc_smooth_filter
  import adcf_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [UW-1:0] cfg_unit,
  input  logic [TW-1:0] cfg_tag,
  input  logic [CW-1:0] cfg_code,
  input  logic          clr_i,
  input  logic          in_valid,
  input  logic [TW-1:0] in_tag,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [TW-1:0] out_tag,
  output logic [DW-1:0] out_data,
  output logic          out_filtered
);
  logic [NUNITS-1:0] unit_hit;
  logic [DW-1:0]     unit_filt [NUNITS];

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    logic unit_we;
    assign unit_we = cfg_we && (cfg_unit == UW'(u));
    adcf_unit i_unit (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr_i),
      .cfg_we   (unit_we),
      .cfg_tag  (cfg_tag),
      .cfg_code (cfg_code),
      .in_valid (in_valid),
      .in_tag   (in_tag),
      .in_data  (in_data),
      .hit      (unit_hit[u]),
      .filt     (unit_filt[u])
    );
  end

  adcf_out i_out (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_tag       (in_tag),
    .in_data      (in_data),
    .hits         (unit_hit),
    .filts        (unit_filt),
    .out_valid    (out_valid),
    .out_tag      (out_tag),
    .out_data     (out_data),
    .out_filtered (out_filtered)
  );

  // R7: one-cycle latency for every result
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid && out_tag == $past(in_tag));
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R5: unmatched results pass unchanged
  a_r5_passthru: assert property (@(posedge clk) disable iff (rst)
    in_valid && unit_hit == '0 |=> !out_filtered && out_data == $past(in_data));
  // R8: unit 0 has priority when both match
  a_r8_priority: assert property (@(posedge clk) disable iff (rst)
    in_valid && unit_hit[0] |=> out_data == $past(unit_filt[0]));
endmodule

// File: tb/adc_smooth_filter_test.sv
`timescale 1ns/1ps
module adc_smooth_filter_test;
  logic        clk = 0;
  logic        rst;
  logic        cfg_we = 0;
  logic [0:0]  cfg_unit = 0;
  logic [3:0]  cfg_tag = 0;
  logic [2:0]  cfg_code = 0;
  logic        clr_i = 0;
  logic        in_valid = 0;
  logic [3:0]  in_tag = 0;
  logic [11:0] in_data = 0;
  logic        out_valid;
  logic [3:0]  out_tag;
  logic [11:0] out_data;
  logic        out_filtered;

  int checks = 0;
  int errors = 0;

  // bench model of the two units
  int m_acc [2];
  bit m_prim [2];
  int m_sel [2];
  int m_code [2];

  always #10 clk = ~clk;

  adc_smooth_filter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
    .cfg_tag(cfg_tag), .cfg_code(cfg_code), .clr_i(clr_i),
    .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data),
    .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data),
    .out_filtered(out_filtered)
  );

  // stimulus table: {tag, data}
  localparam logic [15:0] VEC [16] = '{
    {4'h3, 12'd1000}, {4'h3, 12'd2000}, {4'h9, 12'd4095}, {4'h2, 12'd77},
    {4'h3, 12'd0},    {4'h9, 12'd0},    {4'h3, 12'd4095}, {4'h7, 12'd3333},
    {4'h9, 12'd1234}, {4'h3, 12'd4095}, {4'hF, 12'd5},    {4'h3, 12'd17},
    {4'h9, 12'd4095}, {4'h1, 12'd4000}, {4'h3, 12'd2048}, {4'h9, 12'd9}
  };

  function automatic int kof(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      4: return 16;
      5: return 64;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int u = 0; u < 2; u++) begin
      m_sel[u] = 15; m_code[u] = 0; m_prim[u] = 0; m_acc[u] = 0;
    end
  endtask

  task automatic configure(int unit, int tag, int code);
    @(negedge clk);
    cfg_we = 1; cfg_unit = 1'(unit); cfg_tag = 4'(tag); cfg_code = 3'(code);
    @(negedge clk);
    cfg_we = 0;
    m_sel[unit] = tag; m_code[unit] = code; m_prim[unit] = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_i = 1;
    @(negedge clk);
    clr_i = 0;
    m_prim[0] = 0; m_prim[1] = 0;
  endtask

  // drive one result at a negedge, check at the following negedge
  task automatic send_chk(int tag, int data, string req);
    int  exp_data;
    bit  exp_filt;
    bit  first;
    exp_data = data;
    exp_filt = 0;
    first    = 1;
    for (int u = 0; u < 2; u++) begin
      int k;
      k = kof(m_code[u]);
      if (m_sel[u] != 15 && k != 0 && m_sel[u] == tag) begin
        if (!m_prim[u]) m_acc[u] = data * 64;
        else m_acc[u] = m_acc[u] - m_acc[u] / k + (data * 64) / k;
        m_prim[u] = 1;
        if (first) exp_data = m_acc[u] / 64;
        first = 0;
        exp_filt = 1;
      end
    end
    in_valid = 1; in_tag = 4'(tag); in_data = 12'(data);
    @(negedge clk);
    in_valid = 0;
    check(out_valid == 1'b1, {req, " R7 valid"}, int'(out_valid), 1);
    check(out_tag == 4'(tag), {req, " R7 tag"}, int'(out_tag), tag);
    check(out_data == 12'(exp_data), {req, " data"}, int'(out_data), exp_data);
    check(out_filtered == exp_filt, {req, " filtered flag"}, int'(out_filtered), int'(exp_filt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    send_chk(15, 321, "R1 disabled after reset");
    send_chk(3, 654, "R1 no unit active");
    @(negedge clk);
    check(out_valid == 1'b0, "R7 idle cycle", int'(out_valid), 0);

    // R9: per-unit configuration, table walk for R3/R4/R5
    configure(0, 3, 2);  // unit 0: tag 3, k=4
    configure(1, 9, 5);  // unit 1: tag 9, k=64
    for (int i = 0; i < 16; i++)
      send_chk(int'(VEC[i][15:12]), int'(VEC[i][11:0]), "R4 table");

    // R6: clear restarts the average, keeps configuration
    clear_all();
    send_chk(3, 500, "R6 load after clear");
    send_chk(9, 4000, "R6 load after clear unit1");
    send_chk(3, 1500, "R4 average after clear");

    // R2: every legal factor against full-scale steps
    for (int c = 1; c <= 5; c++) begin
      configure(1, 5, c);
      send_chk(5, 4095, "R3 first load");
      for (int n = 0; n < 6; n++) send_chk(5, (n % 2 == 0) ? 0 : 4095, "R2 factor step");
    end

    // R2: disabling codes and selector
    configure(1, 5, 0);
    send_chk(5, 1111, "R2 code 0 off");
    configure(1, 5, 6);
    send_chk(5, 2222, "R2 code 6 off");
    configure(1, 5, 7);
    send_chk(5, 3333, "R2 code 7 off");
    configure(0, 15, 3);
    send_chk(15, 444, "R2 selector F off");

    // R8: both units on one tag, unit 0 wins, unit 1 still updates
    configure(0, 12, 1);
    configure(1, 12, 4);
    send_chk(12, 800, "R8 shared first");
    send_chk(12, 3000, "R8 shared second");
    send_chk(12, 100, "R8 shared third");
    configure(0, 15, 0);
    send_chk(12, 2600, "R8 unit1 state kept");

    // R5: unmatched results leave unit state alone
    send_chk(4, 4095, "R5 pass");
    send_chk(12, 2600, "R5 unit state intact");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule